// File: doc/BRIEF.md
# Modulo-Scheduled Loop Branch Controller

This block performs the counter bookkeeping and the branch decision of a counted loop branch used by software-pipelined (modulo-scheduled) loops. One branch instruction steps a pipelined loop through all three of its phases: filling the pipeline, running the steady state, and draining it. Two counters hold the state. The iteration counter still holds work to start. The drain counter holds the number of extra passes needed to finish the stages that are already in flight.

Each accepted evaluation decides whether the branch is taken or falls through, and it updates the counters. It then sends a one-cycle rotate strobe to the register renamer and shifts one bit into a vector of stage predicates. A 1 is injected while new iterations are still starting. A 0 is injected while the pipeline drains. Bit 0 of the vector gates the first stage, bit 1 the second, and so on up the vector. Before the loop is entered, software loads both counters and the predicate vector. For example, a 3-stage loop over 5 elements is loaded with iteration count 4, drain count 3 and predicate vector 1.

Top module: `swp_loop_branch`

## Requirements
- R1: After a synchronous active-low reset, both counters, the predicate vector, `taken`, `rotate` and `inject_bit` are all 0.
- R2: An accepted evaluation with a nonzero iteration counter has these effects:
  - the iteration counter decrements by 1 and the drain counter is unchanged;
  - the predicate vector shifts and takes in a 1;
  - `rotate`, `taken` and `inject_bit` are 1 in the cycle after the strobe.
- R3: An accepted evaluation with a zero iteration counter and a drain counter greater than 1 decrements the drain counter and shifts in a 0. In the next cycle `rotate` and `taken` are 1 and `inject_bit` is 0.
- R4: An accepted evaluation with a zero iteration counter and a drain counter equal to 1 sets the drain counter to 0 and shifts in a 0. In the next cycle `rotate` is 1 and `taken` is 0. `taken` is never 1 without `rotate`.
- R5: An accepted evaluation with both counters at 0 falls through. `taken` and `rotate` stay 0, and the counters and the predicate vector are unchanged.
- R6: If any of `lc_wr`, `ec_wr` or `pred_wr` is high in the same cycle as `br_exec`, the write takes effect and the evaluation is discarded. No pulse is produced, and the predicate vector changes only if `pred_wr` is high.
- R7: `taken` and `rotate` are single-cycle pulses. Both are 0 in any cycle that does not directly follow an accepted `br_exec`.
- R8: On each rotation, predicate bit i moves to bit i+1, the injected bit enters bit 0, and the highest bit is discarded.
- R9: Counters are `CNT_W` bits wide (64 by default). A decrement borrows across the whole width; for example, 0x1_0000_0000 becomes 0xFFFF_FFFF.
- R10: Loaded with iteration count 4, drain count 3 and predicate vector 1, the controller does the following:
  - the first six evaluations are taken;
  - the seventh evaluation rotates and falls through;
  - the low predicate bits read 0x03, 0x07, 0x0F, 0x1F, 0x3E, 0x7C and 0xF8 after successive evaluations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lc_wr | input | 1 | Load strobe for the iteration counter |
| lc_wdata | input | CNT_W | Iteration counter load value |
| ec_wr | input | 1 | Load strobe for the drain counter |
| ec_wdata | input | CNT_W | Drain counter load value |
| pred_wr | input | 1 | Load strobe for the predicate vector |
| pred_wdata | input | NUM_PRED | Predicate vector load value |
| br_exec | input | 1 | Evaluate the loop branch this cycle |
| taken | output | 1 | Branch taken pulse |
| rotate | output | 1 | Register rotation pulse to the renamer |
| inject_bit | output | 1 | Bit shifted into predicate 0 by the last rotation |
| lc_val | output | CNT_W | Current iteration counter |
| ec_val | output | CNT_W | Current drain counter |
| stage_pred | output | NUM_PRED | Stage predicate vector, bit 0 gates the first stage |

## Verification
The bound checker checks the following on every cycle:
- each of the four decision cases against the counter values one cycle earlier;
- that writes win over a same-cycle evaluation;
- that pulses appear only after an accepted evaluation;
- that every rotation is an exact one-place shift carrying the injected bit.

The bench scenarios cover the rest:
- the reset values;
- the full fill, steady-state and drain sequence of a complete loop, including the exact predicate patterns;
- the final fall-through;
- a borrow across the 32-bit boundary of the counter;
- loss of the top predicate bit.

// File: rtl/swpb_pkg.sv
// Shared types for the loop branch controller.
// Assumes: decision cases are mutually exclusive and cover all counter states.
package swpb_pkg;

    typedef enum logic [1:0] {
        BR_FILL  = 2'd0,   // iteration counter nonzero
        BR_DRAIN = 2'd1,   // draining, more than one pass left
        BR_LAST  = 2'd2,   // final drain pass
        BR_IDLE  = 2'd3    // nothing left
    } br_case_e;

    typedef struct packed {
        logic taken;
        logic rotate;
        logic inject;
        logic dec_lc;
        logic dec_ec;
    } br_action_t;

endpackage

// File: rtl/swpb_decide.sv
// Combinational branch decision from the two counters.
// Assumes: counters are unsigned; the caller gates the action with acceptance.
module swpb_decide
    import swpb_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic [CNT_W-1:0] lc,
    input  logic [CNT_W-1:0] ec,
    output br_case_e         kind,
    output br_action_t       act
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Classify the counter state.
    always_comb begin
        if (lc != '0)       kind = BR_FILL;
        else if (ec > ONE)  kind = BR_DRAIN;
        else if (ec == ONE) kind = BR_LAST;
        else                kind = BR_IDLE;
    end

    // Map the case onto the actions it triggers.
    always_comb begin
        act = '0;
        unique case (kind)
            BR_FILL:  begin act.taken = 1'b1; act.rotate = 1'b1; act.inject = 1'b1; act.dec_lc = 1'b1; end
            BR_DRAIN: begin act.taken = 1'b1; act.rotate = 1'b1; act.dec_ec = 1'b1; end
            BR_LAST:  begin act.rotate = 1'b1; act.dec_ec = 1'b1; end
            default:  act = '0;
        endcase
    end

endmodule

// File: rtl/swpb_counters.sv
// Iteration and drain counters with a load port each.
// Assumes: a load wins over a decrement in the same cycle.
module swpb_counters #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lc_wr,
    input  logic [CNT_W-1:0] lc_wdata,
    input  logic             ec_wr,
    input  logic [CNT_W-1:0] ec_wdata,
    input  logic             dec_lc,
    input  logic             dec_ec,
    output logic [CNT_W-1:0] lc_q,
    output logic [CNT_W-1:0] ec_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Iteration counter: reset, load, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)      lc_q <= '0;
        else if (lc_wr)  lc_q <= lc_wdata;
        else if (dec_lc) lc_q <= lc_q - ONE;
    end

    // Drain counter: reset, load, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)      ec_q <= '0;
        else if (ec_wr)  ec_q <= ec_wdata;
        else if (dec_ec) ec_q <= ec_q - ONE;
    end

endmodule

// File: rtl/swpb_stage_preds.sv
// Stage predicate shift register; bit 0 gates the first stage.
// Assumes: a load wins over a shift; the top bit is dropped on a shift.
module swpb_stage_preds #(
    parameter int NUM_PRED = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [NUM_PRED-1:0] load_data,
    input  logic                shift,
    input  logic                shift_in,
    output logic [NUM_PRED-1:0] preds
);

    logic [NUM_PRED-1:0] nxt;

    genvar i;
    generate
        for (i = 0; i < NUM_PRED; i++) begin : g_bit
            logic below;
            if (i == 0) begin : g_head
                assign below = shift_in;
            end else begin : g_body
                assign below = preds[i-1];
            end
            // Next value of predicate bit i.
            always_comb begin
                if (load)       nxt[i] = load_data[i];
                else if (shift) nxt[i] = below;
                else            nxt[i] = preds[i];
            end
        end
    endgenerate

    // Register the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) preds <= '0;
        else        preds <= nxt;
    end

endmodule

// File: rtl/swp_loop_branch.sv
// Top of the modulo-scheduled loop branch controller.
// Assumes: an evaluation is discarded if any load strobe is high in its cycle;
// taken/rotate/inject_bit are registered one cycle after the accepted strobe.
module swp_loop_branch
    import swpb_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int NUM_PRED = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lc_wr,
    input  logic [CNT_W-1:0]    lc_wdata,
    input  logic                ec_wr,
    input  logic [CNT_W-1:0]    ec_wdata,
    input  logic                pred_wr,
    input  logic [NUM_PRED-1:0] pred_wdata,
    input  logic                br_exec,
    output logic                taken,
    output logic                rotate,
    output logic                inject_bit,
    output logic [CNT_W-1:0]    lc_val,
    output logic [CNT_W-1:0]    ec_val,
    output logic [NUM_PRED-1:0] stage_pred
);

    br_case_e   kind;
    br_action_t act;
    logic       accept;

    assign accept = br_exec && !(lc_wr || ec_wr || pred_wr);

    swpb_decide #(.CNT_W(CNT_W)) u_decide (
        .lc   (lc_val),
        .ec   (ec_val),
        .kind (kind),
        .act  (act)
    );

    swpb_counters #(.CNT_W(CNT_W)) u_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .lc_wr    (lc_wr),
        .lc_wdata (lc_wdata),
        .ec_wr    (ec_wr),
        .ec_wdata (ec_wdata),
        .dec_lc   (accept && act.dec_lc),
        .dec_ec   (accept && act.dec_ec),
        .lc_q     (lc_val),
        .ec_q     (ec_val)
    );

    swpb_stage_preds #(.NUM_PRED(NUM_PRED)) u_preds (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pred_wr),
        .load_data (pred_wdata),
        .shift     (accept && act.rotate),
        .shift_in  (act.inject),
        .preds     (stage_pred)
    );

    // Register the outcome pulses of an accepted evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken      <= 1'b0;
            rotate     <= 1'b0;
            inject_bit <= 1'b0;
        end else begin
            taken      <= accept && act.taken;
            rotate     <= accept && act.rotate;
            inject_bit <= accept && act.inject;
        end
    end

endmodule

// File: rtl/swpb_checker.sv
// Cycle-by-cycle properties of the loop branch controller, bound to the top.
// Assumes: the bench holds rst_n low across the first clock edge.
module swpb_checker #(
    parameter int CNT_W    = 64,
    parameter int NUM_PRED = 48
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lc_wr,
    input logic [CNT_W-1:0]    lc_wdata,
    input logic                ec_wr,
    input logic                pred_wr,
    input logic                br_exec,
    input logic                taken,
    input logic                rotate,
    input logic                inject_bit,
    input logic [CNT_W-1:0]    lc_val,
    input logic [CNT_W-1:0]    ec_val,
    input logic [NUM_PRED-1:0] stage_pred
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic acc;
    assign acc = br_exec && !lc_wr && !ec_wr && !pred_wr;

    p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && lc_val != '0) |=> (lc_val == $past(lc_val) - ONE) && taken && inject_bit);

    p_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && lc_val == '0 && ec_val > ONE) |=> (ec_val == $past(ec_val) - ONE) && taken && rotate && !inject_bit);

    p_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && lc_val == '0 && ec_val == ONE) |=> (ec_val == '0) && rotate && !taken);

    p_taken_rot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> rotate);

    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && lc_val == '0 && ec_val == '0) |=> !rotate && !taken && $stable(stage_pred) && $stable(ec_val));

    p_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_wr || ec_wr || pred_wr) |=> !rotate && !taken);

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lc_wr |=> lc_val == $past(lc_wdata));

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !br_exec |=> !rotate && !taken);

    p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rotate |-> (stage_pred[NUM_PRED-1:1] == $past(stage_pred[NUM_PRED-2:0])) && (stage_pred[0] == inject_bit));

endmodule

bind swp_loop_branch swpb_checker #(.CNT_W(CNT_W), .NUM_PRED(NUM_PRED)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lc_wr      (lc_wr),
    .lc_wdata   (lc_wdata),
    .ec_wr      (ec_wr),
    .pred_wr    (pred_wr),
    .br_exec    (br_exec),
    .taken      (taken),
    .rotate     (rotate),
    .inject_bit (inject_bit),
    .lc_val     (lc_val),
    .ec_val     (ec_val),
    .stage_pred (stage_pred)
);

// File: tb/swp_loop_branch_test.sv
module swp_loop_branch_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 64;
    localparam int NUM_PRED   = 48;
    localparam int NVEC       = 16;

    // Vector: op(1) lc(8) ec(8) pred(8) | exp taken(1) rotate(1) lc(8) ec(8) pred(8)
    // op 1 = load all three, op 0 = branch evaluation
    localparam logic [50:0] VEC [NVEC] = '{
        {1'b1, 8'd4, 8'd3, 8'h01, 1'b0, 1'b0, 8'd4, 8'd3, 8'h01},  // R10 setup
        {1'b0, 8'd0, 8'd0, 8'h00, 1'b1, 1'b1, 8'd3, 8'd3, 8'h03},  // R2
        {1'b0, 8'd0, 8'd0, 8'h00, 1'b1, 1'b1, 8'd2, 8'd3, 8'h07},
        {1'b0, 8'd0, 8'd0, 8'h00, 1'b1, 1'b1, 8'd1, 8'd3, 8'h0F},
        {1'b0, 8'd0, 8'd0, 8'h00, 1'b1, 1'b1, 8'd0, 8'd3, 8'h1F},
        {1'b0, 8'd0, 8'd0, 8'h00, 1'b1, 1'b1, 8'd0, 8'd2, 8'h3E},  // R3
        {1'b0, 8'd0, 8'd0, 8'h00, 1'b1, 1'b1, 8'd0, 8'd1, 8'h7C},
        {1'b0, 8'd0, 8'd0, 8'h00, 1'b0, 1'b1, 8'd0, 8'd0, 8'hF8},  // R4
        {1'b0, 8'd0, 8'd0, 8'h00, 1'b0, 1'b0, 8'd0, 8'd0, 8'hF8},  // R5
        {1'b1, 8'd0, 8'd1, 8'hFF, 1'b0, 1'b0, 8'd0, 8'd1, 8'hFF},
        {1'b0, 8'd0, 8'd0, 8'h00, 1'b0, 1'b1, 8'd0, 8'd0, 8'hFE},  // R4 R8
        {1'b1, 8'd2, 8'd0, 8'h00, 1'b0, 1'b0, 8'd2, 8'd0, 8'h00},
        {1'b0, 8'd0, 8'd0, 8'h00, 1'b1, 1'b1, 8'd1, 8'd0, 8'h01},  // R2
        {1'b0, 8'd0, 8'd0, 8'h00, 1'b1, 1'b1, 8'd0, 8'd0, 8'h03},
        {1'b0, 8'd0, 8'd0, 8'h00, 1'b0, 1'b0, 8'd0, 8'd0, 8'h03},  // R5
        {1'b0, 8'd0, 8'd0, 8'h00, 1'b0, 1'b0, 8'd0, 8'd0, 8'h03}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                lc_wr = 1'b0, ec_wr = 1'b0, pred_wr = 1'b0, br_exec = 1'b0;
    logic [CNT_W-1:0]    lc_wdata = '0, ec_wdata = '0;
    logic [NUM_PRED-1:0] pred_wdata = '0;
    logic                taken, rotate, inject_bit;
    logic [CNT_W-1:0]    lc_val, ec_val;
    logic [NUM_PRED-1:0] stage_pred;

    int nchecks = 0;
    int nerrs   = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swp_loop_branch #(.CNT_W(CNT_W), .NUM_PRED(NUM_PRED)) uut (
        .clk(clk), .rst_n(rst_n),
        .lc_wr(lc_wr), .lc_wdata(lc_wdata),
        .ec_wr(ec_wr), .ec_wdata(ec_wdata),
        .pred_wr(pred_wr), .pred_wdata(pred_wdata),
        .br_exec(br_exec),
        .taken(taken), .rotate(rotate), .inject_bit(inject_bit),
        .lc_val(lc_val), .ec_val(ec_val), .stage_pred(stage_pred)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at the falling edge, release at the next falling edge.
    task automatic step(input logic l, input logic e, input logic p, input logic b);
        lc_wr = l; ec_wr = e; pred_wr = p; br_exec = b;
        @(negedge clk);
        lc_wr = 1'b0; ec_wr = 1'b0; pred_wr = 1'b0; br_exec = 1'b0;
    endtask

    task automatic load_all(input logic [63:0] l, input logic [63:0] e, input logic [NUM_PRED-1:0] p);
        lc_wdata = l; ec_wdata = e; pred_wdata = p;
        step(1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            nerrs++; nchecks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerrs, nchecks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1 reset state
        check("R1 lc", lc_val, 64'd0);
        check("R1 ec", ec_val, 64'd0);
        check("R1 pred", 64'(stage_pred), 64'd0);
        check("R1 pulses", {61'd0, taken, rotate, inject_bit}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 R8 R10
        for (int k = 0; k < NVEC; k++) begin
            logic [50:0] v;
            v = VEC[k];
            if (v[50]) begin
                load_all(64'(v[49:42]), 64'(v[41:34]), NUM_PRED'(v[33:26]));
            end else begin
                step(1'b0, 1'b0, 1'b0, 1'b1);
            end
            check($sformatf("R10 vec%0d taken", k), 64'(taken), 64'(v[25]));
            check($sformatf("R10 vec%0d rotate", k), 64'(rotate), 64'(v[24]));
            check($sformatf("R10 vec%0d lc", k), lc_val, 64'(v[23:16]));
            check($sformatf("R10 vec%0d ec", k), ec_val, 64'(v[15:8]));
            check($sformatf("R10 vec%0d pred", k), 64'(stage_pred[7:0]), 64'(v[7:0]));
        end

        // R7 pulse lasts one cycle
        load_all(64'd3, 64'd1, '0);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 pulse high", 64'(taken), 64'd1);
        @(negedge clk);
        check("R7 taken low after", 64'(taken), 64'd0);
        check("R7 rotate low after", 64'(rotate), 64'd0);

        // R6 write wins over same-cycle branch
        load_all(64'd5, 64'd2, NUM_PRED'(8'h05));
        lc_wdata = 64'd9;
        step(1'b1, 1'b0, 1'b0, 1'b1);
        check("R6 lc loaded", lc_val, 64'd9);
        check("R6 ec kept", ec_val, 64'd2);
        check("R6 pred kept", 64'(stage_pred), 64'h05);
        check("R6 no pulse", {62'd0, taken, rotate}, 64'd0);

        // R9 borrow across wide counter
        load_all(64'h1_0000_0000, 64'd0, '0);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R9 borrow", lc_val, 64'h0_FFFF_FFFF);

        // R8 top bit discarded, injected bit enters bit 0
        load_all(64'd1, 64'd0, {1'b1, {(NUM_PRED-1){1'b0}}});
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R8 top dropped", 64'(stage_pred), 64'd1);
        check("R8 inject_bit", 64'(inject_bit), 64'd1);

        // R1 reset mid-run
        load_all(64'd7, 64'd7, '1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid lc", lc_val, 64'd0);
        check("R1 mid ec", ec_val, 64'd0);
        check("R1 mid pred", 64'(stage_pred), 64'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerrs, nchecks);
        $finish;
    end

endmodule